// File: doc/BRIEF.md
# Power-Management Event Register Block

This block holds the event status, event enable and control registers of a power-management unit, together with a free-running power-management timer. It raises a level-sensitive system control interrupt while at least one of four event sources has both its status bit and its enable bit set. Software reaches the registers through a 64-byte I/O window. The base of that window and its enable come from configuration inputs, so the window can be placed anywhere in a 16-bit I/O space on a 64-byte boundary.

Hardware event pulses set the status bits for the RTC alarm, the power button and the global lock. A fourth source is the timer's carry into its top bit. Software clears a status bit by writing 1 to it. The timer advances one count for each cycle in which the tick input is high. Software reads the timer with a 32-bit access.

Top module: `pm_evt_block`

## Requirements
- R1: After reset the status, enable, control and timer registers are all zero, `sci` is low and every read returns zero.
- R2: An access is decoded only while `cfg_win_en` is 1 and `io_addr[15:6]` equals `cfg_win_base`. Any other access reads as zero and changes no register.
- R3: Within the window only `io_addr[3:0]` selects a register, so offset 0x12 reaches the same register as offset 0x02.
- R4: Status bits are: bit 0 timer carry, bit 5 global lock, bit 8 power button, bit 10 RTC alarm. An event pulse sets its bit on the next clock edge whatever the enable register holds. All other status bits read 0.
- R5: A 16-bit write at offset 0x0 clears each status bit written with 1 and leaves bits written with 0 unchanged. An event arriving in the same cycle as a clear of its bit leaves the bit set.
- R6: Offset 0x2 is a 16-bit enable register that reads back every bit written.
- R7: Offset 0x4 is a 16-bit control register that reads back what was written, except bit 13 (sleep enable), which always reads 0.
- R8: The timer is a TMR_W-bit counter (24 by default) that advances by one on every cycle with `tmr_tick` high and wraps to zero. A 32-bit read at offset 0x8 returns it zero-extended.
- R9: The timer status bit (bit 0) sets on the edge where the timer's top bit changes value, in either direction.
- R10: `sci` is high exactly while (status AND enable) is non-zero over bits 0, 5, 8 and 10. Enable bits outside those four have no effect on `sci`.
- R11: 32-bit writes change no register. Offsets without a register read as zero and ignore writes. A 16-bit read at offset 0x8 and a 32-bit read at any offset except 0x8 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_win_base | input | 10 | Window base, I/O address bits 15:6 |
| cfg_win_en | input | 1 | Window decode enable |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe |
| io_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| io_wdata | input | 16 | Write data |
| io_rdata | output | 32 | Read data, valid in the cycle of `io_rd` |
| evt_rtc | input | 1 | RTC alarm event pulse |
| evt_pwrbtn | input | 1 | Power-button event pulse |
| evt_glock | input | 1 | Global-lock event pulse |
| tmr_tick | input | 1 | Timer advance enable |
| sci | output | 1 | System control interrupt, level |

## Verification
Directed sequences set each enable bit alone, or set only bits outside the four interrupt sources, before an event fires. This separates correct interrupt qualification from a mask that is too wide or too narrow. Clears that land in the same cycle as an event show whether set wins over clear. Accesses at aliased offsets, outside the window and with the window disabled show whether the decoder compares the right address bits. A random phase then mixes reads, writes of both sizes, event pulses and dense timer ticks against a cycle model, and carries the timer through both top-bit transitions.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int STS_TMR_BIT   = 0;
  localparam int STS_GLOCK_BIT = 5;
  localparam int STS_PBTN_BIT  = 8;
  localparam int STS_RTC_BIT   = 10;
  localparam int CTL_SLEEP_BIT = 13;
  localparam int REG_W         = 16;

  localparam logic [REG_W-1:0] EVT_MASK =
    REG_W'((1 << STS_TMR_BIT) | (1 << STS_GLOCK_BIT) |
           (1 << STS_PBTN_BIT) | (1 << STS_RTC_BIT));

  localparam logic [3:0] OFF_STS = 4'h0;
  localparam logic [3:0] OFF_EN  = 4'h2;
  localparam logic [3:0] OFF_CTL = 4'h4;
  localparam logic [3:0] OFF_TMR = 4'h8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STS,
    SEL_EN,
    SEL_CTL,
    SEL_TMR
  } reg_sel_e;
endpackage

// File: rtl/pm_io_decode.sv
module pm_io_decode
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_LG = 6,
  parameter int SEL_W  = 4
) (
  input  logic [ADDR_W-1:0]      io_addr,
  input  logic [ADDR_W-WIN_LG-1:0] win_base,
  input  logic                   win_en,
  input  logic                   io_wide,
  input  logic                   io_wr,
  output reg_sel_e               sel,
  output logic                   wr_sts,
  output logic                   wr_en,
  output logic                   wr_ctl
);
  logic             hit;
  logic [SEL_W-1:0] off;
  logic             unused_mid;

  assign hit        = win_en && (io_addr[ADDR_W-1:WIN_LG] == win_base);
  assign off        = io_addr[SEL_W-1:0];
  assign unused_mid = ^io_addr[WIN_LG-1:SEL_W];

  always_comb begin
    sel = SEL_NONE;
    if (hit) begin
      if (!io_wide) begin
        case (off)
          SEL_W'(OFF_STS): sel = SEL_STS;
          SEL_W'(OFF_EN):  sel = SEL_EN;
          SEL_W'(OFF_CTL): sel = SEL_CTL;
          default:         sel = SEL_NONE;
        endcase
      end else if (off == SEL_W'(OFF_TMR)) begin
        sel = SEL_TMR;
      end
    end
  end

  assign wr_sts = io_wr && (sel == SEL_STS);
  assign wr_en  = io_wr && (sel == SEL_EN);
  assign wr_ctl = io_wr && (sel == SEL_CTL);
endmodule

// File: rtl/pm_tmr.sv
module pm_tmr #(
  parameter int TMR_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [TMR_W-1:0] cnt_q,
  output logic             msb_flip
);
  logic [TMR_W-1:0] cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (tick) cnt_nxt = cnt_q + TMR_W'(1);
  end

  assign msb_flip = cnt_nxt[TMR_W-1] ^ cnt_q[TMR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == $past(cnt_q) + TMR_W'(1)); // R8
  AST_TMR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q)); // R8
  AST_TMR_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    msb_flip |=> cnt_q[TMR_W-1] != $past(cnt_q[TMR_W-1])); // R9
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sts,
  input  logic             wr_en,
  input  logic             wr_ctl,
  input  logic [REG_W-1:0] wdata,
  input  logic [REG_W-1:0] evt_set,
  output logic [REG_W-1:0] sts_q,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] ctl_q,
  output logic             sci
);
  logic [REG_W-1:0] sts_nxt, en_nxt, ctl_nxt, clr_vec;

  always_comb begin
    clr_vec = wr_sts ? wdata : '0;
    sts_nxt = ((sts_q & ~clr_vec) | evt_set) & EVT_MASK;
    en_nxt  = wr_en  ? wdata : en_q;
    ctl_nxt = ctl_q;
    if (wr_ctl) begin
      ctl_nxt = wdata;
      ctl_nxt[CTL_SLEEP_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      en_q  <= '0;
      ctl_q <= '0;
    end else begin
      sts_q <= sts_nxt;
      en_q  <= en_nxt;
      ctl_q <= ctl_nxt;
    end
  end

  assign sci = |(sts_q & en_q & EVT_MASK);

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_set & EVT_MASK)) |=>
      ((sts_q & $past(evt_set & EVT_MASK)) == $past(evt_set & EVT_MASK))); // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && !(|evt_set)) |=> ((sts_q & $past(wdata)) == '0)); // R5
  AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_q)); // R11
  AST_SCI_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sci) |-> ($past(|evt_set) || $past(wr_en))); // R10
endmodule

// File: rtl/pm_evt_block.sv
module pm_evt_block
  import pm_evt_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int WIN_LG = 6,
  parameter int SEL_W  = 4,
  parameter int TMR_W  = 24
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-WIN_LG-1:0] cfg_win_base,
  input  logic                     cfg_win_en,
  input  logic [ADDR_W-1:0]        io_addr,
  input  logic                     io_wr,
  input  logic                     io_rd,
  input  logic                     io_wide,
  input  logic [REG_W-1:0]         io_wdata,
  output logic [31:0]              io_rdata,
  input  logic                     evt_rtc,
  input  logic                     evt_pwrbtn,
  input  logic                     evt_glock,
  input  logic                     tmr_tick,
  output logic                     sci
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  reg_sel_e         sel;
  logic             wr_sts, wr_en, wr_ctl;
  logic [TMR_W-1:0] tmr_q;
  logic             tmr_flip;
  logic [REG_W-1:0] evt_set;
  logic [REG_W-1:0] sts_q, en_q, ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pm_io_decode #(.ADDR_W(ADDR_W), .WIN_LG(WIN_LG), .SEL_W(SEL_W)) u_dec (
    .io_addr (io_addr),
    .win_base(cfg_win_base),
    .win_en  (cfg_win_en),
    .io_wide (io_wide),
    .io_wr   (io_wr),
    .sel     (sel),
    .wr_sts  (wr_sts),
    .wr_en   (wr_en),
    .wr_ctl  (wr_ctl)
  );

  pm_tmr #(.TMR_W(TMR_W)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .tick    (tmr_tick),
    .cnt_q   (tmr_q),
    .msb_flip(tmr_flip)
  );

  always_comb begin
    evt_set                = '0;
    evt_set[STS_TMR_BIT]   = tmr_flip;
    evt_set[STS_GLOCK_BIT] = evt_glock;
    evt_set[STS_PBTN_BIT]  = evt_pwrbtn;
    evt_set[STS_RTC_BIT]   = evt_rtc;
  end

  pm_evt_regs u_regs (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .wr_sts (wr_sts),
    .wr_en  (wr_en),
    .wr_ctl (wr_ctl),
    .wdata  (io_wdata),
    .evt_set(evt_set),
    .sts_q  (sts_q),
    .en_q   (en_q),
    .ctl_q  (ctl_q),
    .sci    (sci)
  );

  always_comb begin
    io_rdata = '0;
    if (io_rd) begin
      case (sel)
        SEL_STS: io_rdata = 32'(sts_q);
        SEL_EN:  io_rdata = 32'(en_q);
        SEL_CTL: io_rdata = 32'(ctl_q);
        SEL_TMR: io_rdata = 32'(tmr_q);
        default: io_rdata = '0;
      endcase
    end
  end

  AST_CTL_SLEEP_RD: assert property (@(posedge clk) disable iff (!rst_int_n)
    (io_rd && sel == SEL_CTL) |-> !io_rdata[CTL_SLEEP_BIT]); // R7
  AST_WIDE_WR_IGN: assert property (@(posedge clk) disable iff (!rst_int_n)
    (io_wr && io_wide) |-> !(wr_sts || wr_en || wr_ctl)); // R11
endmodule

// File: tb/pm_evt_block_test.sv
`timescale 1ns/1ps
module pm_evt_block_test;
  localparam int TW = 10;
  localparam logic [15:0] MASK = 16'h0521;
  localparam logic [9:0]  BASE = 10'h2C0; // window at 0xB000

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  cfg_win_base;
  logic        cfg_win_en;
  logic [15:0] io_addr;
  logic        io_wr, io_rd, io_wide;
  logic [15:0] io_wdata;
  logic [31:0] io_rdata;
  logic        evt_rtc, evt_pwrbtn, evt_glock, tmr_tick;
  logic        sci;

  int checks = 0;
  int errors = 0;

  logic [15:0]   m_sts, m_en, m_ctl;
  logic [TW-1:0] m_tmr;

  always #4 clk = ~clk;

  pm_evt_block #(.TMR_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_win_base(cfg_win_base), .cfg_win_en(cfg_win_en),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wide(io_wide),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .evt_rtc(evt_rtc),
    .evt_pwrbtn(evt_pwrbtn), .evt_glock(evt_glock), .tmr_tick(tmr_tick), .sci(sci)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic in_win(input logic [15:0] a);
    return cfg_win_en && (a[15:6] == cfg_win_base);
  endfunction

  function automatic logic [31:0] m_read(input logic wide, input logic [15:0] a);
    if (!in_win(a)) return 32'h0;
    if (!wide) begin
      case (a[3:0])
        4'h0: return {16'h0, m_sts};
        4'h2: return {16'h0, m_en};
        4'h4: return {16'h0, m_ctl};
        default: return 32'h0;
      endcase
    end
    return (a[3:0] == 4'h8) ? 32'(m_tmr) : 32'h0;
  endfunction

  function automatic logic m_sci();
    return |(m_sts & m_en & MASK);
  endfunction

  // ev: bit0 rtc, bit1 power button, bit2 global lock, bit3 tick
  task automatic cyc(input logic wr, input logic rd, input logic wide,
                     input logic [15:0] a, input logic [15:0] d,
                     input logic [3:0] ev, input string req);
    logic [TW-1:0] t_nxt;
    logic [15:0]   setv, clrv;
    logic          hit16;
    @(negedge clk);
    io_wr = wr; io_rd = rd; io_wide = wide; io_addr = a; io_wdata = d;
    evt_rtc = ev[0]; evt_pwrbtn = ev[1]; evt_glock = ev[2]; tmr_tick = ev[3];
    #1;
    if (rd) chk(req, io_rdata, m_read(wide, a));
    chk("R10 sci", {31'h0, sci}, {31'h0, m_sci()});
    @(posedge clk);
    t_nxt = ev[3] ? m_tmr + 1'b1 : m_tmr;
    setv = 16'h0;
    setv[0]  = t_nxt[TW-1] ^ m_tmr[TW-1];
    setv[5]  = ev[2];
    setv[8]  = ev[1];
    setv[10] = ev[0];
    hit16 = in_win(a) && wr && !wide;
    clrv = (hit16 && a[3:0] == 4'h0) ? d : 16'h0;
    m_sts = ((m_sts & ~clrv) | setv) & MASK;
    if (hit16 && a[3:0] == 4'h2) m_en = d;
    if (hit16 && a[3:0] == 4'h4) m_ctl = d & 16'hDFFF;
    m_tmr = t_nxt;
  endtask

  task automatic idle(); cyc(1'b0, 1'b0, 1'b0, 16'h0, 16'h0, 4'h0, "idle"); endtask
  task automatic wr16(input logic [15:0] a, input logic [15:0] d);
    cyc(1'b1, 1'b0, 1'b0, a, d, 4'h0, "wr");
  endtask
  task automatic rd16(input logic [15:0] a, input string req);
    cyc(1'b0, 1'b1, 1'b0, a, 16'h0, 4'h0, req);
  endtask
  task automatic rd32(input logic [15:0] a, input string req);
    cyc(1'b0, 1'b1, 1'b1, a, 16'h0, 4'h0, req);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd2024;
    void'($urandom(seed));
    rst_n = 1'b0; cfg_win_base = BASE; cfg_win_en = 1'b1;
    io_addr = '0; io_wr = 0; io_rd = 0; io_wide = 0; io_wdata = '0;
    evt_rtc = 0; evt_pwrbtn = 0; evt_glock = 0; tmr_tick = 0;
    m_sts = '0; m_en = '0; m_ctl = '0; m_tmr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset values
    rd16(16'hB000, "R1 status"); rd16(16'hB002, "R1 enable");
    rd16(16'hB004, "R1 control"); rd32(16'hB008, "R1 timer");
    chk("R1 sci", {31'h0, sci}, 32'h0);

    // R6 enable readback, R10 qualification
    wr16(16'hB002, 16'hFFFF); rd16(16'hB002, "R6 enable all ones");
    wr16(16'hB002, 16'hA5C3); rd16(16'hB002, "R6 enable pattern");
    // R4 event sets status though disabled, R10 no sci from non-source enables
    wr16(16'hB002, 16'hFADE);
    cyc(0, 0, 0, 16'h0, 16'h0, 4'b0100, "R4 glock");
    rd16(16'hB000, "R4 glock status without enable");
    chk("R10 sci stays low", {31'h0, sci}, 32'h0);
    wr16(16'hB002, 16'h0020);
    idle(); chk("R10 sci from glock", {31'h0, sci}, 32'h1);
    cyc(0, 0, 0, 16'h0, 16'h0, 4'b0011, "R4 rtc pb");
    rd16(16'hB000, "R4 rtc and power button");
    // R5 write 1 clears, 0 keeps
    wr16(16'hB000, 16'h0020); rd16(16'hB000, "R5 clear glock only");
    chk("R5 sci low after clear", {31'h0, sci}, 32'h0);
    // R5 set wins over simultaneous clear
    cyc(1, 0, 0, 16'hB000, 16'hFFFF, 4'b0001, "R5 set wins");
    rd16(16'hB000, "R5 rtc survives clear");
    wr16(16'hB000, 16'hFFFF); rd16(16'hB000, "R5 clear all");

    // R7 control with write-only sleep bit
    wr16(16'hB004, 16'hFFFF); rd16(16'hB004, "R7 sleep bit reads 0");
    wr16(16'hB004, 16'h1234); rd16(16'hB004, "R7 control pattern");

    // R3 aliasing on low nibble
    wr16(16'hB012, 16'h0100); rd16(16'hB002, "R3 alias write");
    rd16(16'hB034, "R3 alias read");

    // R2 window decode
    wr16(16'hB042, 16'h7777); rd16(16'hB002, "R2 outside window no write");
    rd16(16'hB042, "R2 outside reads zero");
    cfg_win_en = 1'b0;
    wr16(16'hB002, 16'h3333); rd16(16'hB002, "R2 disabled reads zero");
    cfg_win_en = 1'b1;
    rd16(16'hB002, "R2 disabled write ignored");
    cfg_win_base = 10'h011; // window at 0x0440
    wr16(16'h0442, 16'h0400); rd16(16'h0442, "R2 relocated window");
    rd16(16'hB002, "R2 old base dead");
    cfg_win_base = BASE;

    // R11 wide writes, unmapped offsets
    cyc(1, 0, 1, 16'hB002, 16'h0000, 4'h0, "wide wr");
    rd16(16'hB002, "R11 wide write ignored");
    wr16(16'hB006, 16'hFFFF); rd16(16'hB006, "R11 unmapped reads zero");
    rd16(16'hB008, "R11 narrow timer read zero");
    rd32(16'hB002, "R11 wide read of enable zero");

    // R8 timer counts ticks
    repeat (37) cyc(0, 0, 0, 16'h0, 16'h0, 4'b1000, "tick");
    rd32(16'hB008, "R8 timer after ticks");
    rd32(16'hB018, "R8 timer aliased");

    // R9 timer top bit toggle both ways
    wr16(16'hB002, 16'h0001); wr16(16'hB000, 16'hFFFF);
    while (m_tmr[TW-1] == 1'b0) cyc(0, 0, 0, 16'h0, 16'h0, 4'b1000, "tick");
    rd16(16'hB000, "R9 status on rising top bit");
    chk("R9 sci from timer", {31'h0, sci}, 32'h1);
    wr16(16'hB000, 16'h0001);
    while (m_tmr[TW-1] == 1'b1) cyc(0, 0, 0, 16'h0, 16'h0, 4'b1000, "tick");
    rd16(16'hB000, "R9 status on falling top bit");
    rd32(16'hB008, "R8 timer wrapped");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [15:0] a, d;
      logic [3:0]  ev;
      logic        wr, rd, wide;
      int unsigned r;
      r    = $urandom;
      a    = (r[3:0] == 4'h0) ? 16'($urandom) : {BASE, 2'b00, r[7:4] & 4'hE};
      d    = 16'($urandom);
      wr   = ($urandom % 4) == 0;
      rd   = !wr && (($urandom % 2) == 0);
      wide = ($urandom % 4) == 0;
      ev   = 4'b0000;
      ev[0] = ($urandom % 16) == 0;
      ev[1] = ($urandom % 16) == 0;
      ev[2] = ($urandom % 16) == 0;
      ev[3] = ($urandom % 4) != 0;
      cyc(wr, rd, wide, a, d, ev, "R4 R5 R6 R7 R8 R9 R11 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule